// File: doc/BRIEF.md
# Doorbell Command Mailbox

This block is a memory-mapped mailbox that lets a host pass commands to a device-side executor. The host uses a little-endian register bus. Each access carries a byte address, a size code for 1, 2, 4 or 8 bytes, and write data; read data returns one cycle later. The mailbox window has five registers followed by a 2048-byte payload area:

- a 32-bit capability word,
- a 32-bit control word whose bit 0 is the doorbell,
- a 64-bit command word,
- a 64-bit result status word,
- a 64-bit background-progress word.

The host loads the payload and the command word, then sets the doorbell. The block takes a snapshot of the payload for the executor and presents the host with a zeroed payload. It then pulses a request to the executor, which reads the snapshot through its own read port. When the executor signals done, the block writes the return code and the background flag into the status word. It also rewrites the command word with the output length and clears the doorbell.

Register writes are filtered by address and by width. Some reads have side effects: an 8-byte read of the progress word captures live progress inputs, and an 8-byte read of the status word can drop the background flag.

Top module: `mbox_regif`

## Requirements
- R1: After reset, the capability word at 0x00 reads 0x0000026B, and every other register reads zero. The capability fields are: payload exponent 11 in [4:0], background-interrupt support 1 in bit 5, interrupt message 9 in [9:6], and ready time and mailbox type zero in [21:10].
- R2: A 4-byte write is stored only at 0x00 (capability) or 0x04 (control). A 4-byte write to any other register address is ignored, and so is a 1- or 2-byte write anywhere below 0x20.
- R3: An 8-byte write is stored only at 0x08 (command) or 0x18 (progress). An 8-byte write to 0x10 (status) is dropped.
- R4: A write of any size at or above 0x20 stores its bytes little-endian into the payload at byte offset (address − 0x20), 2048 bytes in all. Such a write starts no command.
- R5: An access whose address is not a multiple of its size is ignored if it is a write, and reads back zero if it is a read.
- R6: After a register write that leaves the doorbell set while no command is in flight, exec_req pulses for exactly one cycle in the next cycle. The pulse carries the command (bits [7:0]), the command set ([15:8]) and the input length ([27:16]) taken from the command word.
- R7: Once a command starts, the executor reads, through exec_rd_word and exec_rd_data, the payload as it stood before the doorbell. From the next cycle on, the host sees an all-zero payload.
- R8: The cycle after exec_done, the following are visible:
  - The status word holds the background-started flag in bit 0 and the return code in [47:32], with all other bits zero.
  - The command word holds the same command and command set, with the output length in [27:16].
  - The doorbell is clear.
- R9: While a command is in flight, the doorbell stays set even if the host writes control bit 0 as zero, and no further request is issued. Reads return the current register and payload values.
- R10: An 8-byte read of 0x18 returns the live progress: opcode in [15:0], percent complete in [22:16] and return code in [47:32]. The same value is stored, so later narrow reads return it.
- R11: An 8-byte read of 0x10 clears the stored background flag, and returns it cleared, whenever the percent-complete input is nonzero.
- R12: Read data appears with rvalid one cycle after the read. Narrower reads return the addressed bytes at bit 0, with zero above. The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address within the mailbox window |
| bus_size | input | 2 | Size code (log2 of the byte count) |
| bus_wdata | input | 64 | Write data, right-aligned |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Read data, right-aligned |
| exec_req | output | 1 | One-cycle command request |
| exec_cmd_set | output | 8 | Command set of the request |
| exec_cmd | output | 8 | Command of the request |
| exec_len_in | output | 12 | Input payload length |
| exec_rd_word | input | 8 | Snapshot word index |
| exec_rd_data | output | 64 | Snapshot word contents |
| exec_done | input | 1 | Command finished |
| exec_rc | input | 16 | Return code |
| exec_bg_started | input | 1 | Command went to background |
| exec_len_out | input | 12 | Output payload length |
| bg_opcode | input | 16 | Current background opcode |
| bg_pct | input | 7 | Background percent complete |
| bg_rc | input | 16 | Background return code |

## Verification
The in-RTL properties check several rules on every cycle:
- the request is a single-cycle pulse;
- the doorbell is held for as long as a command is in flight and drops right after completion;
- writes to the status word and misaligned writes leave the stored registers untouched;
- every read is answered one cycle later;
- the host payload view is all zero straight after a start.

Other behaviour can only be shown through bench scenarios:
- byte placement in the payload and lane extraction on narrow reads;
- the snapshot contents the executor receives;
- the completion rewrite of the command and status words;
- the progress capture and the percent-dependent clearing of the flag.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  // bytes of register space in front of the payload
  localparam int unsigned REG_SPAN = 32;

  // 64-bit register slots, selected by address bits [4:3]
  typedef enum logic [1:0] {
    W_CAPCTL = 2'd0,
    W_CMD    = 2'd1,
    W_STS    = 2'd2,
    W_BGS    = 2'd3
  } reg_word_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_e;

  localparam logic [1:0] SZ_B1 = 2'd0;
  localparam logic [1:0] SZ_B2 = 2'd1;
  localparam logic [1:0] SZ_B4 = 2'd2;
  localparam logic [1:0] SZ_B8 = 2'd3;

  localparam int unsigned DB_BIT      = 0;
  localparam int unsigned CMD_OP_LSB  = 0;
  localparam int unsigned CMD_SET_LSB = 8;
  localparam int unsigned CMD_LEN_LSB = 16;
  localparam int unsigned STS_BG_BIT  = 0;
  localparam int unsigned STS_RC_LSB  = 32;
  localparam int unsigned BGS_OP_LSB  = 0;
  localparam int unsigned BGS_PCT_LSB = 16;
  localparam int unsigned BGS_RC_LSB  = 32;
endpackage

// File: rtl/mbox_decode.sv
`timescale 1ns/1ps
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned PL_BYTES = 2048,
  localparam int unsigned WAW     = $clog2(PL_BYTES / 8)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              aligned,
  output logic              is_reg,
  output logic              is_pl,
  output reg_word_e         rword,
  output logic [2:0]        lane,
  output logic [7:0]        be,
  output logic [63:0]       size_mask,
  output logic [WAW-1:0]    pl_word
);
  localparam logic [ADDR_W-1:0] A_PL_BASE = ADDR_W'(REG_SPAN);
  localparam logic [ADDR_W-1:0] A_PL_END  = ADDR_W'(REG_SPAN + PL_BYTES);

  logic [ADDR_W-1:0] pl_off;
  logic [7:0]        nb_mask;

  always_comb begin
    unique case (size)
      SZ_B1: begin aligned = 1'b1;             nb_mask = 8'h01; end
      SZ_B2: begin aligned = (addr[0] == 1'b0);   nb_mask = 8'h03; end
      SZ_B4: begin aligned = (addr[1:0] == 2'b0); nb_mask = 8'h0F; end
      default: begin aligned = (addr[2:0] == 3'b0); nb_mask = 8'hFF; end
    endcase
  end

  for (genvar b = 0; b < 8; b++) begin : g_mask
    assign size_mask[8*b +: 8] = {8{nb_mask[b]}};
  end

  assign lane    = addr[2:0];
  assign be      = nb_mask << lane;
  assign rword   = reg_word_e'(addr[4:3]);
  assign is_reg  = aligned && (addr < A_PL_BASE);
  assign is_pl   = aligned && (addr >= A_PL_BASE) && (addr < A_PL_END);
  assign pl_off  = addr - A_PL_BASE;
  assign pl_word = pl_off[3 +: WAW];
endmodule

// File: rtl/mbox_payload.sv
`timescale 1ns/1ps
module mbox_payload #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned WAW  = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [WAW-1:0] wr_word,
  input  logic [7:0]     wr_be,
  input  logic [63:0]    wr_data,
  input  logic           swap,
  input  logic [WAW-1:0] host_word,
  output logic [63:0]    host_data,
  input  logic [WAW-1:0] ex_word,
  output logic [63:0]    ex_data
);
  logic             bank_q, bank_d;
  logic [WORDS-1:0] vld_q [2];
  logic [WORDS-1:0] vld_d [2];
  logic [63:0]      mem_q [2][WORDS];
  logic [63:0]      old_w, merged;

  assign old_w = vld_q[bank_q][wr_word] ? mem_q[bank_q][wr_word] : 64'd0;

  for (genvar b = 0; b < 8; b++) begin : g_lane
    assign merged[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : old_w[8*b +: 8];
  end

  always_comb begin
    vld_d  = vld_q;
    bank_d = bank_q;
    if (swap) begin
      bank_d         = ~bank_q;
      vld_d[~bank_q] = '0;
    end else if (wr_en) begin
      vld_d[bank_q][wr_word] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q   <= 1'b0;
      vld_q[0] <= '0;
      vld_q[1] <= '0;
    end else begin
      bank_q <= bank_d;
      vld_q  <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[bank_q][wr_word] <= merged;
  end

  assign host_data = vld_q[bank_q][host_word] ? mem_q[bank_q][host_word] : 64'd0;
  assign ex_data   = vld_q[~bank_q][ex_word] ? mem_q[~bank_q][ex_word] : 64'd0;

  // R7: a start never coincides with a payload write, and the host view is blank afterwards
  assert_swap_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> !wr_en);
  assert_host_view_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (host_data == 64'd0));
endmodule

// File: rtl/mbox_seq.sv
`timescale 1ns/1ps
module mbox_seq
  import mbox_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic done,
  output logic start,
  output logic busy,
  output logic accept,
  output logic exec_req
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:  if (kick) state_d = SQ_ISSUE;
      SQ_ISSUE: state_d = SQ_WAIT;
      SQ_WAIT:  if (done) state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign start    = (state_q == SQ_IDLE) && kick;
  assign busy     = (state_q != SQ_IDLE);
  assign accept   = (state_q == SQ_WAIT) && done;
  assign exec_req = (state_q == SQ_ISSUE);

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req |=> !exec_req);
  assert_start_then_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> exec_req);
endmodule

// File: rtl/mbox_regif.sv
`timescale 1ns/1ps
module mbox_regif
  import mbox_pkg::*;
#(
  parameter int unsigned PL_BYTES = 2048,
  parameter int unsigned IRQ_MSG  = 9,
  localparam int unsigned PL_EXP  = $clog2(PL_BYTES),
  localparam int unsigned LEN_W   = PL_EXP + 1,
  localparam int unsigned WORDS   = PL_BYTES / 8,
  localparam int unsigned WAW     = $clog2(WORDS),
  localparam int unsigned ADDR_W  = $clog2(REG_SPAN + PL_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [63:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [63:0]       bus_rdata,
  output logic              exec_req,
  output logic [7:0]        exec_cmd_set,
  output logic [7:0]        exec_cmd,
  output logic [LEN_W-1:0]  exec_len_in,
  input  logic [WAW-1:0]    exec_rd_word,
  output logic [63:0]       exec_rd_data,
  input  logic              exec_done,
  input  logic [15:0]       exec_rc,
  input  logic              exec_bg_started,
  input  logic [LEN_W-1:0]  exec_len_out,
  input  logic [15:0]       bg_opcode,
  input  logic [6:0]        bg_pct,
  input  logic [15:0]       bg_rc
);
  localparam logic [31:0] CAP_RST = 32'(PL_EXP) | (32'd1 << 5) | (32'(IRQ_MSG) << 6);

  // decode
  logic            aligned, is_reg, is_pl;
  reg_word_e       rword;
  logic [2:0]      lane;
  logic [7:0]      be;
  logic [63:0]     size_mask;
  logic [WAW-1:0]  pl_word;

  mbox_decode #(.ADDR_W(ADDR_W), .PL_BYTES(PL_BYTES)) u_dec (
    .addr(bus_addr), .size(bus_size), .aligned(aligned), .is_reg(is_reg),
    .is_pl(is_pl), .rword(rword), .lane(lane), .be(be),
    .size_mask(size_mask), .pl_word(pl_word)
  );

  // access qualifiers
  logic wr_ok, rd_ok, sz4, sz8, reg_wr, pl_wr, sts_rd8, bgs_rd8, kick;
  logic start, busy, accept;
  logic [63:0] wdata_sh, pl_host_data;

  assign wr_ok    = bus_valid && bus_write;
  assign rd_ok    = bus_valid && !bus_write;
  assign sz4      = (bus_size == SZ_B4);
  assign sz8      = (bus_size == SZ_B8);
  assign reg_wr   = wr_ok && is_reg;
  assign pl_wr    = wr_ok && is_pl;
  assign sts_rd8  = rd_ok && is_reg && sz8 && (rword == W_STS);
  assign bgs_rd8  = rd_ok && is_reg && sz8 && (rword == W_BGS);
  assign wdata_sh = bus_wdata << {lane, 3'b000};

  mbox_payload #(.WORDS(WORDS)) u_pl (
    .clk(clk), .rst_n(rst_n), .wr_en(pl_wr), .wr_word(pl_word), .wr_be(be),
    .wr_data(wdata_sh), .swap(start), .host_word(pl_word),
    .host_data(pl_host_data), .ex_word(exec_rd_word), .ex_data(exec_rd_data)
  );

  // registers
  logic [31:0]      cap_q, cap_d, ctrl_q, ctrl_d;
  logic [63:0]      cmd_q, cmd_d, sts_q, sts_d, bgs_q, bgs_d;
  logic [63:0]      rdata_q, rdata_d;
  logic             rvalid_q;
  logic [7:0]       lset_q, lset_d, lcmd_q, lcmd_d;
  logic [LEN_W-1:0] llen_q, llen_d;
  logic [63:0]      live_bgs, sts_view, reg_val, src_val;

  always_comb begin
    live_bgs = '0;
    live_bgs[BGS_OP_LSB  +: 16] = bg_opcode;
    live_bgs[BGS_PCT_LSB +: 7]  = bg_pct;
    live_bgs[BGS_RC_LSB  +: 16] = bg_rc;
    sts_view = sts_q;
    if (bg_pct != 7'd0) sts_view[STS_BG_BIT] = 1'b0;
  end

  always_comb begin
    unique case (rword)
      W_CAPCTL: reg_val = {ctrl_q, cap_q};
      W_CMD:    reg_val = cmd_q;
      W_STS:    reg_val = sz8 ? sts_view : sts_q;
      default:  reg_val = sz8 ? live_bgs : bgs_q;
    endcase
    if (is_reg)     src_val = reg_val;
    else if (is_pl) src_val = pl_host_data;
    else            src_val = 64'd0;
    rdata_d = rd_ok ? ((src_val >> {lane, 3'b000}) & size_mask) : 64'd0;
  end

  // next-state for the register file
  always_comb begin
    cap_d  = cap_q;
    ctrl_d = ctrl_q;
    cmd_d  = cmd_q;
    sts_d  = sts_q;
    bgs_d  = bgs_q;
    if (reg_wr && sz4 && (rword == W_CAPCTL)) begin
      if (lane == 3'd0) begin
        cap_d = bus_wdata[31:0];
      end else begin
        ctrl_d = bus_wdata[31:0];
        if (busy) ctrl_d[DB_BIT] = ctrl_q[DB_BIT];
      end
    end
    if (reg_wr && sz8 && (rword == W_CMD)) cmd_d = bus_wdata;
    if (reg_wr && sz8 && (rword == W_BGS)) bgs_d = bus_wdata;
    if (sts_rd8) sts_d = sts_view;
    if (bgs_rd8) bgs_d = live_bgs;
    if (accept) begin
      sts_d = '0;
      sts_d[STS_BG_BIT]       = exec_bg_started;
      sts_d[STS_RC_LSB +: 16] = exec_rc;
      cmd_d = '0;
      cmd_d[CMD_OP_LSB  +: 8]     = lcmd_q;
      cmd_d[CMD_SET_LSB +: 8]     = lset_q;
      cmd_d[CMD_LEN_LSB +: LEN_W] = exec_len_out;
      ctrl_d[DB_BIT] = 1'b0;
    end
  end

  assign kick = reg_wr && ctrl_d[DB_BIT];

  always_comb begin
    lset_d = lset_q;
    lcmd_d = lcmd_q;
    llen_d = llen_q;
    if (start) begin
      lset_d = cmd_q[CMD_SET_LSB +: 8];
      lcmd_d = cmd_q[CMD_OP_LSB  +: 8];
      llen_d = cmd_q[CMD_LEN_LSB +: LEN_W];
    end
  end

  mbox_seq u_seq (
    .clk(clk), .rst_n(rst_n), .kick(kick), .done(exec_done), .start(start),
    .busy(busy), .accept(accept), .exec_req(exec_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= CAP_RST;
      ctrl_q   <= '0;
      cmd_q    <= '0;
      sts_q    <= '0;
      bgs_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      lset_q   <= '0;
      lcmd_q   <= '0;
      llen_q   <= '0;
    end else begin
      cap_q    <= cap_d;
      ctrl_q   <= ctrl_d;
      cmd_q    <= cmd_d;
      sts_q    <= sts_d;
      bgs_q    <= bgs_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rd_ok;
      lset_q   <= lset_d;
      lcmd_q   <= lcmd_d;
      llen_q   <= llen_d;
    end
  end

  assign bus_rvalid   = rvalid_q;
  assign bus_rdata    = rdata_q;
  assign exec_cmd_set = lset_q;
  assign exec_cmd     = lcmd_q;
  assign exec_len_in  = llen_q;

  assert_sts_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sz8 && (rword == W_STS) && !accept) |=> $stable(sts_q));
  assert_misaligned_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !aligned && !accept) |=> ($stable(cap_q) && $stable(cmd_q) && $stable(bgs_q)));
  assert_done_clears_db_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ctrl_q[DB_BIT]);
  assert_db_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ctrl_q[DB_BIT]);
  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> bus_rvalid);
endmodule

// File: tb/tb_mbox_regif.sv
`timescale 1ns/1ps
module tb_mbox_regif;
  localparam int AW = 12;
  localparam int LW = 12;
  localparam int WW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [63:0]   bus_wdata;
  logic          bus_rvalid;
  logic [63:0]   bus_rdata;
  logic          exec_req;
  logic [7:0]    exec_cmd_set, exec_cmd;
  logic [LW-1:0] exec_len_in;
  logic [WW-1:0] exec_rd_word;
  logic [63:0]   exec_rd_data;
  logic          exec_done;
  logic [15:0]   exec_rc;
  logic          exec_bg_started;
  logic [LW-1:0] exec_len_out;
  logic [15:0]   bg_opcode, bg_rc;
  logic [6:0]    bg_pct;

  always #2.5 clk = ~clk;

  mbox_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .exec_req(exec_req),
    .exec_cmd_set(exec_cmd_set), .exec_cmd(exec_cmd), .exec_len_in(exec_len_in),
    .exec_rd_word(exec_rd_word), .exec_rd_data(exec_rd_data),
    .exec_done(exec_done), .exec_rc(exec_rc), .exec_bg_started(exec_bg_started),
    .exec_len_out(exec_len_out), .bg_opcode(bg_opcode), .bg_pct(bg_pct),
    .bg_rc(bg_rc)
  );

  int total = 0;
  int bad   = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver tasks
  task automatic wr(input logic [AW-1:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] s,
                    input logic [63:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = s;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard as read data comes back
  always @(negedge clk) begin
    if (rst_n === 1'b1 && bus_rvalid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("R12 unexpected rvalid", 64'd1, 64'd0);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // stub executor
  int           stub_delay = 20;
  logic [15:0]  stub_rc    = 16'd0;
  logic         stub_bg    = 1'b0;
  logic [LW-1:0] stub_olen = '0;
  int           req_total = 0;
  int           done_cnt  = 0;
  logic [7:0]   got_set, got_cmd;
  logic [LW-1:0] got_len;
  logic [63:0]  snap0, snap1;

  always @(negedge clk) if (rst_n === 1'b1 && exec_req === 1'b1) req_total++;

  initial begin
    exec_done = 1'b0; exec_rd_word = '0;
    exec_rc = '0; exec_bg_started = 1'b0; exec_len_out = '0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && exec_req === 1'b1) begin
        got_set = exec_cmd_set; got_cmd = exec_cmd; got_len = exec_len_in;
        repeat (stub_delay) @(negedge clk);
        exec_rd_word = 8'd0; #0.5; snap0 = exec_rd_data;
        exec_rd_word = 8'd1; #0.5; snap1 = exec_rd_data;
        exec_rc = stub_rc; exec_bg_started = stub_bg; exec_len_out = stub_olen;
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
        done_cnt++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_size = '0; bus_wdata = '0; bg_opcode = '0; bg_pct = '0; bg_rc = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 rvalid in reset", {63'd0, bus_rvalid}, 64'd0);
    chk("R1 exec_req in reset", {63'd0, exec_req}, 64'd0);
    rst_n = 1'b1;

    // R1 reset values
    rd(12'h000, 2'd3, 64'h0000_0000_0000_026B, "R1 cap/ctrl");
    rd(12'h008, 2'd3, 64'd0, "R1 cmd");
    rd(12'h010, 2'd3, 64'd0, "R1 sts");
    rd(12'h018, 2'd3, 64'd0, "R1 bgs");

    // R2 width and address filtering of 4-byte writes
    wr(12'h004, 2'd2, 64'h0F00);
    rd(12'h004, 2'd2, 64'h0F00, "R2 ctrl stored");
    wr(12'h000, 2'd2, 64'hDEAD_0000);
    rd(12'h000, 2'd2, 64'hDEAD_0000, "R2 cap stored");
    wr(12'h000, 2'd2, 64'h026B);
    wr(12'h008, 2'd2, 64'hFFFF_FFFF);
    wr(12'h00C, 2'd1, 64'hFFFF);
    wr(12'h010, 2'd0, 64'hFF);
    rd(12'h008, 2'd3, 64'd0, "R2 cmd ignored");
    rd(12'h010, 2'd3, 64'd0, "R2 sts ignored");

    // R3 8-byte writes
    wr(12'h008, 2'd3, 64'h0000_0000_0010_1234);
    rd(12'h008, 2'd3, 64'h0000_0000_0010_1234, "R3 cmd stored");
    wr(12'h010, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h010, 2'd3, 64'd0, "R3 sts dropped");
    wr(12'h018, 2'd3, 64'h1122_3344_5566_7788);
    rd(12'h018, 2'd2, 64'h5566_7788, "R3 bgs stored");
    rd(12'h01E, 2'd1, 64'h1122, "R12 2-byte lane");

    // R4 payload bytes
    wr(12'h020, 2'd3, 64'h0807_0605_0403_0201);
    wr(12'h028, 2'd0, 64'hAA);
    wr(12'h02A, 2'd1, 64'hBBCC);
    rd(12'h028, 2'd3, 64'h0000_0000_BBCC_00AA, "R4 byte merge");
    rd(12'h021, 2'd0, 64'h02, "R12 1-byte lane");
    rd(12'h024, 2'd2, 64'h0807_0605, "R12 4-byte lane");
    wr(12'h818, 2'd3, 64'hCAFE);
    rd(12'h818, 2'd3, 64'hCAFE, "R4 last word");
    chk("R4 no request", req_total, 0);

    // R5 misaligned accesses
    wr(12'h022, 2'd2, 64'hFFFF_FFFF);
    rd(12'h020, 2'd3, 64'h0807_0605_0403_0201, "R5 misaligned write ignored");
    rd(12'h021, 2'd1, 64'd0, "R5 misaligned read zero");
    wr(12'h00A, 2'd3, 64'hFFFF);
    rd(12'h008, 2'd3, 64'h0000_0000_0010_1234, "R5 cmd untouched");

    // R10 live progress capture
    bg_opcode = 16'hABCD; bg_pct = 7'h32; bg_rc = 16'h0007;
    rd(12'h018, 2'd3, 64'h0000_0007_0032_ABCD, "R10 live");
    rd(12'h018, 2'd2, 64'h0032_ABCD, "R10 stored");
    bg_pct = 7'd0;

    // R6/R7/R8/R9 first command
    stub_delay = 20; stub_rc = 16'h0005; stub_bg = 1'b1; stub_olen = 12'h040;
    wr(12'h004, 2'd2, 64'h1);
    @(negedge clk);
    chk("R6 req count", req_total, 1);
    chk("R6 cmd set", got_set, 8'h12);
    chk("R6 cmd", got_cmd, 8'h34);
    chk("R6 len in", got_len, 12'd16);
    rd(12'h020, 2'd3, 64'd0, "R7 host view zero");
    rd(12'h028, 2'd3, 64'd0, "R7 host view zero w1");
    rd(12'h004, 2'd2, 64'h1, "R9 doorbell set");
    wr(12'h004, 2'd2, 64'h0);
    rd(12'h004, 2'd2, 64'h1, "R9 doorbell held");
    wr(12'h030, 2'd3, 64'h55);
    wr(12'h008, 2'd3, 64'h0000_0000_0020_5678);
    wait (done_cnt == 1);
    @(negedge clk);
    @(negedge clk);
    chk("R7 snapshot w0", snap0, 64'h0807_0605_0403_0201);
    chk("R7 snapshot w1", snap1, 64'h0000_0000_BBCC_00AA);
    chk("R9 single request", req_total, 1);
    rd(12'h008, 2'd3, 64'h0000_0000_0040_1234, "R8 cmd rewritten");
    rd(12'h010, 2'd3, 64'h0000_0005_0000_0001, "R8 sts");
    rd(12'h004, 2'd2, 64'd0, "R8 doorbell clear");
    rd(12'h030, 2'd3, 64'h55, "R9 host write in flight");

    // R11 flag clearing on status read
    rd(12'h010, 2'd3, 64'h0000_0005_0000_0001, "R11 pct zero keeps flag");
    bg_pct = 7'h32;
    rd(12'h010, 2'd3, 64'h0000_0005_0000_0000, "R11 pct nonzero clears");
    bg_pct = 7'd0;
    rd(12'h010, 2'd3, 64'h0000_0005_0000_0000, "R11 flag stays clear");

    // second command: length comes from the rewritten command word
    stub_delay = 3; stub_rc = 16'h0000; stub_bg = 1'b0; stub_olen = 12'h000;
    wr(12'h004, 2'd2, 64'h1);
    @(negedge clk);
    chk("R6 second length", got_len, 12'h040);
    wait (done_cnt == 2);
    @(negedge clk);
    @(negedge clk);
    chk("R7 second snapshot w0", snap0, 64'd0);
    rd(12'h010, 2'd3, 64'd0, "R8 sts second");
    rd(12'h008, 2'd3, 64'h0000_0000_0000_1234, "R8 cmd second");
    rd(12'h030, 2'd3, 64'd0, "R7 host view zero again");

    repeat (3) @(negedge clk);
    chk("R12 scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule